// File: doc/BRIEF.md
# Serial Sample Output Port with Status

This block sits between a filter that delivers 24-bit two's complement samples and a host that collects them over a clocked serial read port. Each accepted sample is stored in a small FIFO together with the status seen when it was written. The port starts every transfer itself. It pulls an active-low ready line down whenever a word is waiting. The host then supplies serial clocks, and the port sends a 32-bit word, most significant bit first.

Each word has two parts. The upper byte is a status byte. Bit 7 is set when the modulator error input was high as the sample was written. Bit 6 marks a time-break. Bit 5 reports that a sample was dropped because the FIFO was full. Bits 4 to 0 are always zero. The lower 24 bits are the sample.

A time-break countdown is started with a pulse and counts system clock cycles. After it expires, the time-break bit goes on the first sample accepted from then on. When the FIFO is full, an incoming sample is discarded. The next word loaded for transmission then carries the overflow bit.

Top module: `serial_sample_port`

## Requirements
- R1: Each transfer is 32 bits: status byte in bits 31:24, then the 24-bit two's complement sample in bits 23:0, sent most significant bit first.
- R2: `rdy_n` is high after reset and whenever no word is waiting. It goes low on its own when a stored word is available.
- R3: While `rdy_n` is low, `sdo` changes only after a falling edge of `sck`, which presents the next bit. The first bit is present as soon as `rdy_n` falls.
- R4: After the 32nd falling edge of `sck`, `rdy_n` returns high for at least one cycle.
- R5: Status bit 7 equals the level of `mod_err` in the cycle the sample was accepted.
- R6: `tbrk_start` loads a countdown of `tbrk_delay` cycles. Status bit 6 is set on the first sample accepted after the countdown expires, and on no earlier or later sample.
- R7: A sample that arrives while the FIFO is full and no word is being removed is discarded. Status bit 5 is set on the next word loaded for transmission and on no later word.
- R8: Words leave in the order their samples were accepted.
- R9: Status bits 4:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 24 | Filtered sample, two's complement |
| mod_err | input | 1 | Modulator error flag |
| tbrk_start | input | 1 | Starts the time-break countdown |
| tbrk_delay | input | 16 | Countdown length in clock cycles |
| sck | input | 1 | Serial clock from the host, idle low, slower than clk |
| rdy_n | output | 1 | Active-low data-ready |
| sdo | output | 1 | Serial data out |

## Verification
The first stimulus is single samples of positive, negative and all-ones values. These show that the field order and bit order are right and that the data is not sign-mangled. A burst of distinct samples with the error flag toggled between them checks FIFO ordering and that each flag is tied to its own sample. A time-break test places samples before, just after and well after the countdown expires. This shows that the marker lands on exactly one sample. A run with the reader held off overfills the buffer. The words that come back then show which samples were dropped, which single word carries the overflow bit, and that the bit does not persist.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int STATUS_W  = 8;
  localparam int ST_ERR    = 7;
  localparam int ST_TBRK   = 6;
  localparam int ST_OVF    = 5;

  typedef enum logic {SH_IDLE, SH_BUSY} sh_state_t;
endpackage

// File: rtl/sop_fifo.sv
module sop_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/sop_stamp.sv
module sop_stamp #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tbrk_start,
  input  logic [TB_W-1:0] tbrk_delay,
  input  logic            accept,
  output logic            tbrk_flag
);
  logic [TB_W-1:0] cnt;
  logic            run;
  logic            expire;

  assign expire = run && !tbrk_start && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      run       <= 1'b0;
      tbrk_flag <= 1'b0;
    end else begin
      if (tbrk_start) begin
        cnt <= tbrk_delay;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) run <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
      tbrk_flag <= (tbrk_flag && !accept) || expire;
    end
  end
endmodule

// File: rtl/sop_shift.sv
module sop_shift
  import sop_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              avail,
  input  logic [WORD_W-1:0] word,
  input  logic              sck,
  output logic              pop,
  output logic              rdy_n,
  output logic              sdo
);
  sh_state_t         st;
  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bitn;
  logic              sck_q;
  logic              fall;

  assign fall = sck_q && !sck;
  assign pop  = (st == SH_IDLE) && avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SH_IDLE;
      shreg <= '0;
      bitn  <= '0;
      sck_q <= 1'b0;
      rdy_n <= 1'b1;
      sdo   <= 1'b0;
    end else begin
      sck_q <= sck;
      case (st)
        SH_IDLE: if (avail) begin
          shreg <= word;
          sdo   <= word[WORD_W-1];
          bitn  <= '0;
          rdy_n <= 1'b0;
          st    <= SH_BUSY;
        end
        SH_BUSY: if (fall) begin
          if (bitn == BW'(WORD_W - 1)) begin
            rdy_n <= 1'b1;
            sdo   <= 1'b0;
            st    <= SH_IDLE;
          end else begin
            shreg <= shreg << 1;
            sdo   <= shreg[WORD_W-2];
            bitn  <= bitn + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_sample_port.sv
module serial_sample_port
  import sop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TB_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                mod_err,
  input  logic                tbrk_start,
  input  logic [TB_W-1:0]     tbrk_delay,
  input  logic                sck,
  output logic                rdy_n,
  output logic                sdo
);
  localparam int WORD_W  = SAMPLE_W + STATUS_W;
  localparam int ENTRY_W = SAMPLE_W + 2;
  localparam int CW      = $clog2(DEPTH) + 1;

  logic               accept, drop, pop;
  logic               fifo_empty, fifo_full;
  logic [CW-1:0]      fifo_count;
  logic [ENTRY_W-1:0] entry_in, entry_out;
  logic               tbrk_flag;
  logic               ovf_pend;
  logic [STATUS_W-1:0] status;
  logic [WORD_W-1:0]  word;

  assign accept = smp_valid && (!fifo_full || pop);
  assign drop   = smp_valid && fifo_full && !pop;

  sop_stamp #(.TB_W(TB_W)) u_stamp (
    .clk(clk), .rst(rst), .tbrk_start(tbrk_start), .tbrk_delay(tbrk_delay),
    .accept(accept), .tbrk_flag(tbrk_flag)
  );

  assign entry_in = {mod_err, tbrk_flag, smp_data};

  sop_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(accept), .wdata(entry_in), .pop(pop),
    .rdata(entry_out), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  // drop and pop never coincide, so set and clear cannot collide
  always_ff @(posedge clk) begin
    if (rst)       ovf_pend <= 1'b0;
    else if (drop) ovf_pend <= 1'b1;
    else if (pop)  ovf_pend <= 1'b0;
  end

  always_comb begin
    status          = '0;
    status[ST_ERR]  = entry_out[ENTRY_W-1];
    status[ST_TBRK] = entry_out[ENTRY_W-2];
    status[ST_OVF]  = ovf_pend;
  end

  assign word = {status, entry_out[SAMPLE_W-1:0]};

  sop_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .avail(!fifo_empty), .word(word), .sck(sck),
    .pop(pop), .rdy_n(rdy_n), .sdo(sdo)
  );
endmodule

// File: rtl/sop_port_chk.sv
module sop_port_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sck,
  input logic          rdy_n,
  input logic          sdo,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic          pop,
  input logic [CW-1:0] fifo_count
);
  logic ck_q;
  always_ff @(posedge clk) begin
    if (rst) ck_q <= 1'b0;
    else     ck_q <= sck;
  end

  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n && !(ck_q && !sck)) |=> $stable(sdo));

  assert_quiet_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (rdy_n && fifo_empty) |=> rdy_n);

  assert_offer_when_waiting_R2: assert property (@(posedge clk) disable iff (rst)
    (rdy_n && !fifo_empty) |=> !rdy_n);

  assert_release_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> $past(ck_q && !sck));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !pop) |=> $stable(fifo_count));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));
endmodule

bind serial_sample_port sop_port_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH) + 1)) u_chk (
  .clk(clk), .rst(rst), .sck(sck), .rdy_n(rdy_n), .sdo(sdo),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .pop(pop),
  .fifo_count(fifo_count)
);

// File: tb/serial_sample_port_test.sv
module serial_sample_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        mod_err = 1'b0;
  logic        tbrk_start = 1'b0;
  logic [15:0] tbrk_delay = '0;
  logic        sck = 1'b0;
  logic        rdy_n, sdo;

  int checks = 0;
  int fails  = 0;
  logic hold_rd = 1'b0;

  typedef struct { logic [31:0] word; string tag; } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_sample_port #(.DEPTH(DEPTH), .TB_W(16)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .mod_err(mod_err), .tbrk_start(tbrk_start), .tbrk_delay(tbrk_delay),
    .sck(sck), .rdy_n(rdy_n), .sdo(sdo)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // driver: one sample, expected word queued only if it will be kept
  task automatic push(input logic [23:0] d, input bit err, input bit tb, input bit ovf,
                      input bit kept, input string tag);
    exp_t e;
    smp_valid = 1'b1; smp_data = d; mod_err = err;
    @(negedge clk);
    smp_valid = 1'b0; mod_err = 1'b0;
    if (kept) begin
      e.word = {err, tb, ovf, 5'b0, d};
      e.tag  = tag;
      expq.push_back(e);
    end
  endtask

  task automatic read_word(output logic [31:0] w, output bit shape_ok);
    shape_ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      w[31-i] = sdo;
      sck = 1'b1;
      @(negedge clk);
      if (sdo !== w[31-i]) shape_ok = 1'b0;
      @(negedge clk);
      sck = 1'b0;
      @(negedge clk);
      if (i == 31) begin
        if (rdy_n !== 1'b1) shape_ok = 1'b0;
      end else if (rdy_n !== 1'b0) shape_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  // monitor
  initial begin
    logic [31:0] w;
    bit sh;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && !hold_rd && rdy_n === 1'b0) begin
        read_word(w, sh);
        check(sh, "R3 R4 bit timing", {31'b0, sh}, 32'h1);
        if (expq.size() == 0) check(1'b0, "R8 unexpected word", w, 32'h0);
        else begin
          e = expq.pop_front();
          check(w === e.word, e.tag, w, e.word);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdy_n === 1'b1, "R2 reset ready", {31'b0, rdy_n}, 32'h1);
    check(sdo === 1'b0, "R2 reset sdo", {31'b0, sdo}, 32'h0);

    push(24'h123456, 0, 0, 0, 1, "R1 R9 positive sample");
    drain();
    push(24'hFFFFF0, 1, 0, 0, 1, "R5 negative sample with error");
    drain();
    push(24'hFFFFFF, 0, 0, 0, 1, "R1 all ones");
    drain();

    push(24'h000001, 1, 0, 0, 1, "R8 R5 burst 0");
    push(24'h800000, 0, 0, 0, 1, "R8 burst 1");
    push(24'h5A5A5A, 1, 0, 0, 1, "R8 R5 burst 2");
    push(24'hA5A5A5, 0, 0, 0, 1, "R8 burst 3");
    push(24'h7FFFFF, 0, 0, 0, 1, "R8 burst 4");
    drain();
    check(rdy_n === 1'b1, "R2 idle after drain", {31'b0, rdy_n}, 32'h1);

    tbrk_delay = 16'd20;
    tbrk_start = 1'b1;
    @(negedge clk);
    tbrk_start = 1'b0;
    push(24'h00AA00, 0, 0, 0, 1, "R6 before expiry");
    repeat (30) @(negedge clk);
    push(24'h00BB00, 0, 1, 0, 1, "R6 first after expiry");
    push(24'h00CC00, 1, 0, 0, 1, "R6 R5 later sample clear");
    drain();

    hold_rd = 1'b1;
    for (int i = 0; i < DEPTH + 3; i++)
      push(24'h100000 + 24'(i), 0, 0, (i == 1), (i <= DEPTH),
           (i == 1) ? "R7 overflow marked" : "R7 R8 overflow run");
    hold_rd = 1'b0;
    drain();
    push(24'h0F0F0F, 0, 0, 0, 1, "R7 overflow not sticky");
    drain();
    check(rdy_n === 1'b1, "R2 final idle", {31'b0, rdy_n}, 32'h1);
    check(expq.size() == 0, "R8 all words seen", 32'(expq.size()), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule